// File: doc/BRIEF.md
# Four-Channel PWM Timer With Buffered Reload

This block is a pulse-width modulation timer. A single prescaler divides the clock and drives one up-counter that all channels share. The counter runs from zero to a programmable top value and then returns to zero. Each of the channels compares the counter with its own compare value and produces two pins: a main pin and a complementary pin. Each pin has its own enable bit and its own inversion bit. A global outputs-on bit forces every pin to its resting level while it is clear.

Software sets up the timer through a small write/read register port. The top value and each compare value can be buffered. When buffering is on, a write only lands in a holding register, and the value takes effect at the next wrap of the counter or at a forced update. The divider value is always buffered. A forced update loads every holding register at once and restarts the prescaler and the counter.

Top module: `pwmt_core`

Register map (word addresses): 0 control, 1 force-update strobe, 2 divider, 3 top, 4 output configuration, 5 counter value (read only), 8+c compare of channel c. Control bits: [0] run, [1] buffer top, [2] outputs on, [8+c] buffer compare of channel c. The output configuration register uses a 4-bit field per channel at bit 4c: +0 main enable, +1 main invert, +2 complementary enable, +3 complementary invert. Writing 1 to bit 0 of the strobe address forces an update.

## Requirements
- R1: After reset the counter reads 0 and every main and complementary pin is 0.
- R2: While running, the counter steps from 0 up to the active top value and then goes to 0. The wrap is an update event, so one period lasts (TOP+1)*(DIV+1) clock cycles.
- R3: The counter advances once every DIV+1 clock cycles and holds its value between those advances.
- R4: Before inversion, a main pin is high while the counter is below the channel's active compare value. So a compare of 0 gives a pin that never goes high, and a compare above TOP gives a pin that is always high.
- R5: Setting an invert bit inverts that pin. A disabled pin rests at its invert bit (0 when not inverted).
- R6: Before inversion, the complementary pin is the inverse of the compare result. It has its own enable and invert bits.
- R7: While outputs-on (control bit 2) is clear, every pin sits at its invert bit.
- R8: With buffer-top set, a new top value takes effect only at the next wrap or forced update. With it clear, the value takes effect on the cycle after the write.
- R9: With buffer-compare set for a channel, a new compare value for that channel takes effect only at an update event. With it clear, the value takes effect at once.
- R10: A forced update sets the counter and the prescaler to 0 on the next cycle and loads every holding register, whether or not the timer is running.
- R11: While run is clear, the counter holds its value and the pins keep their levels.
- R12: A divider write takes effect only at the next update event. Until then the old division ratio continues.
- R13: If the top value is lowered without buffering to a value below the current count, the counter returns to 0 on its next advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | DATA_W | Read data, combinational from rd_addr |
| pwm_p | output | N_CH | Main pins, one per channel |
| pwm_n | output | N_CH | Complementary pins, one per channel |

## Verification
The assertions assume that the only ways to move the counter are the prescaler tick, the wrap and the forced update. They also assume that a write to the strobe address with bit 0 set is a deliberate forced update, which the stimulus issues only between scenarios or as the subject of a test. Mid-period writes of top, compare and divider values are timed against the count value read back at the port, so the expected cycle of effect is known. The duty measurements count high samples over whole periods, which makes each result independent of the phase at which the window starts.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;

    localparam int unsigned ADDR_W = 4;

    // register addresses
    localparam logic [ADDR_W-1:0] A_CTRL  = 4'd0;
    localparam logic [ADDR_W-1:0] A_KICK  = 4'd1;
    localparam logic [ADDR_W-1:0] A_DIV   = 4'd2;
    localparam logic [ADDR_W-1:0] A_TOP   = 4'd3;
    localparam logic [ADDR_W-1:0] A_OCFG  = 4'd4;
    localparam logic [ADDR_W-1:0] A_COUNT = 4'd5;
    localparam logic [ADDR_W-1:0] A_CMP0  = 4'd8;

    // control register bit positions
    localparam int unsigned CTRL_RUN     = 0;
    localparam int unsigned CTRL_TOPBUF  = 1;
    localparam int unsigned CTRL_OUTON   = 2;
    localparam int unsigned CTRL_CMPBUF0 = 8;

    // per-channel output configuration field
    localparam int unsigned OCFG_STRIDE = 4;
    localparam int unsigned OCFG_EN     = 0;
    localparam int unsigned OCFG_POL    = 1;
    localparam int unsigned OCFG_NEN    = 2;
    localparam int unsigned OCFG_NPOL   = 3;

    typedef struct packed {
        logic npol;
        logic nen;
        logic pol;
        logic en;
    } out_cfg_t;

endpackage

// File: rtl/pwmt_regs.sv
module pwmt_regs
    import pwmt_pkg::*;
#(
    parameter int unsigned N_CH   = 4,
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned DIV_W  = 16,
    parameter int unsigned DATA_W = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [DATA_W-1:0]           wr_data,
    input  logic [ADDR_W-1:0]           rd_addr,
    output logic [DATA_W-1:0]           rd_data,
    input  logic [CNT_W-1:0]            count,
    input  logic                        update_evt,
    output logic                        force_upd,
    output logic                        run,
    output logic                        outs_on,
    output logic [N_CH*OCFG_STRIDE-1:0] ocfg,
    output logic [DIV_W-1:0]            div_act,
    output logic [CNT_W-1:0]            top_act,
    output logic [N_CH*CNT_W-1:0]       cmp_act
);

    localparam int unsigned OCFG_W = N_CH * OCFG_STRIDE;

    typedef struct packed {
        logic                             run;
        logic                             topbuf;
        logic                             outon;
        logic [N_CH-1:0]                  cmpbuf;
        logic [DIV_W-1:0]                 div_pre;
        logic [DIV_W-1:0]                 div_act;
        logic [CNT_W-1:0]                 top_pre;
        logic [CNT_W-1:0]                 top_act;
        logic [N_CH-1:0][CNT_W-1:0]       cmp_pre;
        logic [N_CH-1:0][CNT_W-1:0]       cmp_act;
        logic [OCFG_W-1:0]                ocfg;
    } reg_st_t;

    reg_st_t st_d, st_q;
    logic    kick_d;

    wire unused_wr_bits = ^wr_data;

    always_comb begin
        st_d   = st_q;
        kick_d = wr_en && (wr_addr == A_KICK) && wr_data[0];
        if (wr_en) begin
            case (wr_addr)
                A_CTRL: begin
                    st_d.run    = wr_data[CTRL_RUN];
                    st_d.topbuf = wr_data[CTRL_TOPBUF];
                    st_d.outon  = wr_data[CTRL_OUTON];
                    st_d.cmpbuf = wr_data[CTRL_CMPBUF0 +: N_CH];
                end
                A_DIV: st_d.div_pre = wr_data[DIV_W-1:0];
                A_TOP: begin
                    st_d.top_pre = wr_data[CNT_W-1:0];
                    if (!st_q.topbuf) begin
                        st_d.top_act = wr_data[CNT_W-1:0];
                    end
                end
                A_OCFG: st_d.ocfg = wr_data[OCFG_W-1:0];
                default: begin
                    for (int c = 0; c < N_CH; c++) begin
                        if (wr_addr == ADDR_W'(A_CMP0 + c)) begin
                            st_d.cmp_pre[c] = wr_data[CNT_W-1:0];
                            if (!st_q.cmpbuf[c]) begin
                                st_d.cmp_act[c] = wr_data[CNT_W-1:0];
                            end
                        end
                    end
                end
            endcase
        end
        // transfer of holding registers at wrap or forced update
        if (kick_d || update_evt) begin
            st_d.div_act = st_d.div_pre;
            st_d.top_act = st_d.top_pre;
            st_d.cmp_act = st_d.cmp_pre;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_CTRL:  rd_data = DATA_W'({st_q.cmpbuf, 5'b0, st_q.outon, st_q.topbuf, st_q.run});
            A_DIV:   rd_data = DATA_W'(st_q.div_pre);
            A_TOP:   rd_data = DATA_W'(st_q.top_pre);
            A_OCFG:  rd_data = DATA_W'(st_q.ocfg);
            A_COUNT: rd_data = DATA_W'(count);
            default: begin
                for (int c = 0; c < N_CH; c++) begin
                    if (rd_addr == ADDR_W'(A_CMP0 + c)) begin
                        rd_data = DATA_W'(st_q.cmp_pre[c]);
                    end
                end
            end
        endcase
    end

    assign force_upd = kick_d;
    assign run       = st_q.run;
    assign outs_on   = st_q.outon;
    assign ocfg      = st_q.ocfg;
    assign div_act   = st_q.div_act;
    assign top_act   = st_q.top_act;
    assign cmp_act   = st_q.cmp_act;

endmodule

// File: rtl/pwmt_timebase.sv
module pwmt_timebase #(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             force_upd,
    input  logic [DIV_W-1:0] div_act,
    input  logic [CNT_W-1:0] top_act,
    output logic [CNT_W-1:0] count,
    output logic             tick,
    output logic             wrap_evt
);

    typedef struct packed {
        logic [DIV_W-1:0] pre;
        logic [CNT_W-1:0] cnt;
    } tb_st_t;

    tb_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        tick     = run && (st_q.pre == div_act);
        // a count already above a lowered top also wraps (R13)
        wrap_evt = tick && (st_q.cnt >= top_act);
        if (force_upd) begin
            st_d.pre = '0;
            st_d.cnt = '0;
        end else if (run) begin
            if (tick) begin
                st_d.pre = '0;
                st_d.cnt = wrap_evt ? '0 : st_q.cnt + CNT_W'(1);
            end else begin
                st_d.pre = st_q.pre + DIV_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count = st_q.cnt;

endmodule

// File: rtl/pwmt_channel.sv
module pwmt_channel
    import pwmt_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             outs_on,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] cmp,
    input  out_cfg_t         cfg,
    output logic             pin_p,
    output logic             pin_n
);

    logic below;

    always_comb begin
        below = (count < cmp);
        pin_p = (outs_on && cfg.en  &&  below) ^ cfg.pol;
        pin_n = (outs_on && cfg.nen && !below) ^ cfg.npol;
    end

endmodule

// File: rtl/pwmt_core.sv
module pwmt_core
    import pwmt_pkg::*;
#(
    parameter int unsigned N_CH   = 4,
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned DIV_W  = 16,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [3:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [3:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [N_CH-1:0]   pwm_p,
    output logic [N_CH-1:0]   pwm_n
);

    localparam int unsigned OCFG_W = N_CH * OCFG_STRIDE;

    logic                  force_upd;
    logic                  run;
    logic                  outs_on;
    logic [OCFG_W-1:0]     ocfg;
    logic [DIV_W-1:0]      div_act;
    logic [CNT_W-1:0]      top_act;
    logic [N_CH*CNT_W-1:0] cmp_act;
    logic [CNT_W-1:0]      count;
    logic                  tick;
    logic                  wrap_evt;

    pwmt_regs #(
        .N_CH(N_CH), .CNT_W(CNT_W), .DIV_W(DIV_W), .DATA_W(DATA_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .count(count), .update_evt(wrap_evt),
        .force_upd(force_upd), .run(run), .outs_on(outs_on),
        .ocfg(ocfg), .div_act(div_act), .top_act(top_act), .cmp_act(cmp_act)
    );

    pwmt_timebase #(
        .CNT_W(CNT_W), .DIV_W(DIV_W)
    ) u_tb (
        .clk(clk), .rst_n(rst_n),
        .run(run), .force_upd(force_upd),
        .div_act(div_act), .top_act(top_act),
        .count(count), .tick(tick), .wrap_evt(wrap_evt)
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        pwmt_channel #(
            .CNT_W(CNT_W)
        ) u_ch (
            .outs_on(outs_on),
            .count(count),
            .cmp(cmp_act[c*CNT_W +: CNT_W]),
            .cfg(out_cfg_t'(ocfg[c*OCFG_STRIDE +: OCFG_STRIDE])),
            .pin_p(pwm_p[c]),
            .pin_n(pwm_n[c])
        );
    end

endmodule

// File: rtl/pwmt_core_chk.sv
module pwmt_core_chk
    import pwmt_pkg::*;
#(
    parameter int unsigned N_CH  = 4,
    parameter int unsigned CNT_W = 16
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [CNT_W-1:0]            count,
    input logic [CNT_W-1:0]            top_act,
    input logic                        tick,
    input logic                        force_upd,
    input logic                        run,
    input logic                        outs_on,
    input logic [N_CH*OCFG_STRIDE-1:0] ocfg,
    input logic [N_CH-1:0]             pwm_p,
    input logic [N_CH-1:0]             pwm_n
);

    logic [N_CH-1:0] pol_v, npol_v, en_v, nen_v;

    always_comb begin
        for (int c = 0; c < N_CH; c++) begin
            pol_v[c]  = ocfg[c*OCFG_STRIDE + OCFG_POL];
            npol_v[c] = ocfg[c*OCFG_STRIDE + OCFG_NPOL];
            en_v[c]   = ocfg[c*OCFG_STRIDE + OCFG_EN];
            nen_v[c]  = ocfg[c*OCFG_STRIDE + OCFG_NEN];
        end
    end

    // R7
    outputs_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !outs_on |-> (pwm_p == pol_v) && (pwm_n == npol_v));

    // R10
    force_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        force_upd |=> (count == '0));

    // R2
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !force_upd && (count >= top_act)) |=> (count == '0));

    // R3
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !force_upd && (count < top_act)) |=> (count == $past(count) + CNT_W'(1)));

    // R3
    between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !force_upd) |=> $stable(count));

    // R11
    stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !force_upd) |=> $stable(count) && $stable(pwm_p) && $stable(pwm_n));

    for (genvar c = 0; c < N_CH; c++) begin : g_pair
        // R6
        complement_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (outs_on && en_v[c] && nen_v[c]) |-> ((pwm_p[c] ^ pol_v[c]) != (pwm_n[c] ^ npol_v[c])));
    end

endmodule

bind pwmt_core pwmt_core_chk #(.N_CH(N_CH), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .count(count), .top_act(top_act), .tick(tick),
    .force_upd(force_upd), .run(run), .outs_on(outs_on), .ocfg(ocfg),
    .pwm_p(pwm_p), .pwm_n(pwm_n)
);

// File: tb/pwmt_core_test.sv
module pwmt_core_test;
    import pwmt_pkg::*;

    localparam int N = 4;
    localparam int CW = 16;
    localparam int DATAW = 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [3:0]       wr_addr = '0;
    logic [DATAW-1:0] wr_data = '0;
    logic [3:0]       rd_addr = A_COUNT;
    logic [DATAW-1:0] rd_data;
    logic [N-1:0]     pwm_p, pwm_n;

    int total = 0;
    int bad = 0;
    int hp[N];
    int hn[N];
    int cmax, czero;

    always #10 clk = ~clk;

    pwmt_core #(.N_CH(N), .CNT_W(CW), .DIV_W(16), .DATA_W(DATAW)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .pwm_p(pwm_p), .pwm_n(pwm_n)
    );

    task automatic check(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int cnt();
        return int'(rd_data[CW-1:0]);
    endfunction

    task automatic wr(logic [3:0] a, logic [DATAW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_count(int v);
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (cnt() == v) return;
        end
    endtask

    task automatic measure(int n);
        for (int c = 0; c < N; c++) begin hp[c] = 0; hn[c] = 0; end
        cmax = 0; czero = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            for (int c = 0; c < N; c++) begin
                hp[c] += int'(pwm_p[c]);
                hn[c] += int'(pwm_n[c]);
            end
            if (cnt() > cmax) cmax = cnt();
            if (cnt() == 0) czero++;
        end
    endtask

    task automatic setup(int dv, int tp, int c0, int c1, int c2, int c3, int oc, int ctl);
        wr(A_DIV, DATAW'(dv));
        wr(A_CTRL, DATAW'(ctl));
        wr(A_TOP, DATAW'(tp));
        wr(A_CMP0 + 4'd0, DATAW'(c0));
        wr(A_CMP0 + 4'd1, DATAW'(c1));
        wr(A_CMP0 + 4'd2, DATAW'(c2));
        wr(A_CMP0 + 4'd3, DATAW'(c3));
        wr(A_OCFG, DATAW'(oc));
        wr(A_KICK, 1);
    endtask

    task automatic t_reset();
        check("R1", "count after reset", cnt(), 0);
        check("R1", "main pins after reset", int'(pwm_p), 0);
        check("R1", "compl pins after reset", int'(pwm_n), 0);
    endtask

    task automatic t_basic();
        setup(0, 9, 3, 5, 0, 12, 'h5555, 'h5);
        measure(20);
        check("R4", "ch0 high", hp[0], 6);
        check("R4", "ch1 high", hp[1], 10);
        check("R4", "ch2 cmp zero", hp[2], 0);
        check("R4", "ch3 cmp above top", hp[3], 20);
        check("R6", "ch0 compl high", hn[0], 14);
        check("R6", "ch3 compl high", hn[3], 0);
        check("R2", "max count", cmax, 9);
        check("R2", "zeros in two periods", czero, 2);
    endtask

    task automatic t_prescale();
        setup(2, 9, 3, 5, 0, 12, 'h5555, 'h5);
        measure(30);
        check("R3", "ch0 high div3", hp[0], 9);
        check("R3", "ch1 high div3", hp[1], 15);
        check("R3", "zero samples div3", czero, 3);
        check("R2", "max count div3", cmax, 9);
    endtask

    task automatic t_polarity();
        // ch0: en,pol,nen ; ch1: en,nen,npol ; ch2: pol only ; ch3: off
        setup(0, 9, 3, 4, 0, 12, 'h02D7, 'h5);
        measure(10);
        check("R5", "ch0 inverted main", hp[0], 7);
        check("R6", "ch0 compl plain", hn[0], 7);
        check("R5", "ch1 main", hp[1], 4);
        check("R6", "ch1 inverted compl", hn[1], 4);
        check("R5", "ch2 disabled inverted rests high", hp[2], 10);
        check("R5", "ch2 disabled compl rests low", hn[2], 0);
        check("R5", "ch3 disabled main", hp[3], 0);
        // outputs-on cleared
        wr(A_CTRL, 'h1);
        measure(10);
        check("R7", "ch0 main at invert level", hp[0], 10);
        check("R7", "ch1 main at invert level", hp[1], 0);
        check("R7", "ch0 compl at invert level", hn[0], 0);
        check("R7", "ch1 compl at invert level", hn[1], 10);
    endtask

    task automatic t_stop_force();
        int c0;
        logic [N-1:0] p0, n0;
        setup(0, 9, 3, 5, 0, 12, 'h5555, 'h5);
        wait_count(4);
        wr(A_CTRL, 'h4);
        c0 = cnt(); p0 = pwm_p; n0 = pwm_n;
        repeat (15) @(negedge clk);
        check("R11", "count held while stopped", cnt(), c0);
        check("R11", "main pins held", int'(pwm_p), int'(p0));
        check("R11", "compl pins held", int'(pwm_n), int'(n0));
        check("R11", "stopped count nonzero", int'(c0 != 0), 1);
        wr(A_KICK, 1);
        check("R10", "count after forced update", cnt(), 0);
        repeat (5) @(negedge clk);
        check("R10", "still zero while stopped", cnt(), 0);
    endtask

    task automatic t_top_buffer();
        int mb, ma, seen0, fz, idx;
        // buffered
        setup(0, 9, 3, 5, 0, 12, 'h5555, 'h7);
        wait_count(2);
        wr(A_TOP, 4);
        mb = 0; ma = 0; seen0 = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (cnt() == 0) seen0 = 1;
            if (seen0 == 0 && cnt() > mb) mb = cnt();
            if (seen0 == 1 && cnt() > ma) ma = cnt();
        end
        check("R8", "buffered top: old top kept", mb, 9);
        check("R8", "buffered top: new top after wrap", ma, 4);
        // unbuffered
        setup(0, 9, 3, 5, 0, 12, 'h5555, 'h5);
        wait_count(2);
        wr(A_TOP, 7);
        measure(30);
        check("R8", "unbuffered top applies at once", cmax, 7);
        // lowered below current count
        wr(A_TOP, 9);
        wr(A_KICK, 1);
        wait_count(5);
        wr(A_TOP, 3);
        fz = -1; ma = 0; idx = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (fz < 0 && cnt() == 0) fz = i;
            if (fz >= 0 && cnt() > ma) ma = cnt();
        end
        idx = (fz >= 0 && fz <= 2) ? 1 : 0;
        check("R13", "wrap soon after top lowered below count", idx, 1);
        check("R13", "max count after lowering", ma, 3);
    endtask

    task automatic t_cmp_buffer();
        int viol;
        // ch0 compare buffered, ch1 not
        setup(0, 9, 3, 5, 0, 12, 'h5555, 'h105);
        wait_count(1);
        wr(A_CMP0 + 4'd0, 8);
        wr(A_CMP0 + 4'd1, 2);
        viol = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (cnt() == 0) break;
            if (cnt() >= 3 && pwm_p[0]) viol++;
        end
        check("R9", "buffered compare not applied mid-period", viol, 0);
        measure(10);
        check("R9", "buffered compare after update", hp[0], 8);
        check("R9", "unbuffered compare immediate", hp[1], 2);
    endtask

    task automatic t_div_buffer();
        int s0, s3;
        setup(0, 9, 3, 5, 0, 12, 'h5555, 'h5);
        wait_count(1);
        wr(A_DIV, 4);
        s0 = cnt();
        repeat (3) @(negedge clk);
        s3 = cnt();
        check("R12", "old divider until update", s3 - s0, 3);
        wait_count(0);
        measure(50);
        check("R12", "ch0 high with new divider", hp[0], 15);
        check("R12", "ch1 high with new divider", hp[1], 25);
        check("R12", "zero samples with new divider", czero, 5);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_prescale();
        t_polarity();
        t_stop_force();
        t_top_buffer();
        t_cmp_buffer();
        t_div_buffer();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule